// File: doc/BRIEF.md
# DRAM Bank Address Extension Multiplexer

This block lets a CPU with a 16-bit address space reach four 64 KB banks of DRAM. It produces one extra multiplexed DRAM address line. Two bank-select bits come from an external bank register. The existing row/column strobe that already multiplexes the lower DRAM address lines also chooses which bank bit appears on the extra line. The low bank bit is driven in the row phase and the high bank bit in the column phase.

Two fixed address windows can be marked as common memory. One is the lowest 2 KB of the CPU map, which holds the stack and the video memory. The other is the 2 KB just above 0xC800. Each window has its own enable. While the CPU address lies in an enabled window, the extra line is driven low in both phases. Every access to that window then lands in bank 0, whatever bank is selected. The override is purely combinational on the current address, so it adds no latency to the DRAM address path. The line is actively driven low rather than released to a pull-down.

Top module: `dram_bank_ma8`

## Requirements
- R1: In the row phase (`col_sel` = 0) with no enabled common window hit, `ma8` equals `bank[0]` (the A16 bank bit).
- R2: In the column phase (`col_sel` = 1) with no enabled common window hit, `ma8` equals `bank[1]` (the A17 bank bit).
- R3: When `lo_common_en` = 1 and `cpu_addr` is in 0x0000..0x07FF, `ma8` is 0 in both phases for every bank value.
- R4: When `hi_common_en` = 1 and `cpu_addr` is in 0xC800..0xCFFF, `ma8` is 0 in both phases for every bank value.
- R5: An address inside a window whose enable is 0 gets no override: `ma8` follows R1/R2.
- R6: Addresses just outside the windows (0x0800, 0xC7FF, 0xD000) are never overridden, even with both enables set.
- R7: Each enable acts only on its own window. `lo_common_en` has no effect at 0xC800..0xCFFF, and `hi_common_en` has no effect at 0x0000..0x07FF.
- R8: With `bank` = 0, `ma8` is 0 in both phases whatever the enables and address are.
- R9: `ma8` is combinational. A change on any input appears on `ma8` within the same clock cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 16 | Current CPU address |
| bank | input | 2 | Bank select; bit 0 is A16, bit 1 is A17 |
| lo_common_en | input | 1 | Enables the common window at 0x0000..0x07FF |
| hi_common_en | input | 1 | Enables the common window at 0xC800..0xCFFF |
| col_sel | input | 1 | DRAM address mux strobe: 0 = row phase, 1 = column phase |
| ma8 | output | 1 | Extra multiplexed DRAM address line |

## Verification
All four bank values are driven through both strobe phases, which tells apart a correct phase-to-bit mapping from a swapped one. Addresses at the first and last byte of each window, and one byte outside each edge, are tried with every combination of the two enables. This shows whether the window bounds, the enable gating and the pairing of each enable with its window are correct. A run that alternates an address in and out of a window on every cycle exposes any registered stage on the path. A long pseudo-random sweep, biased toward the window edges, is then checked against a behavioural model on every clock.

// File: rtl/bankx_pkg.sv
package bankx_pkg;

  localparam int CPU_AW = 16;
  localparam int BANK_W = 2;

  typedef enum logic {
    PH_ROW = 1'b0,
    PH_COL = 1'b1
  } phase_e;

  // True when addr lies in the aligned window of 2**span_log2 bytes at base.
  function automatic logic window_hit(input logic [CPU_AW-1:0] addr,
                                      input logic [CPU_AW-1:0] base,
                                      input int                span_log2);
    logic [CPU_AW-1:0] diff;
    diff = (addr ^ base) >> span_log2;
    return (diff == '0);
  endfunction

  // Bank bit that belongs on the extra address line in a given phase.
  function automatic logic phase_pick(input logic [BANK_W-1:0] bank,
                                      input phase_e            ph);
    return (ph == PH_COL) ? bank[1] : bank[0];
  endfunction

endpackage

// File: rtl/bankx_window.sv
module bankx_window
  import bankx_pkg::*;
#(
  parameter logic [CPU_AW-1:0] BASE      = '0,
  parameter int                SPAN_LOG2 = 11
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic              en,
  output logic              hit
);

  logic in_range;

  always_comb begin
    in_range = window_hit(addr, BASE, SPAN_LOG2);
    hit      = en & in_range;
  end

endmodule

// File: rtl/bankx_phase_mux.sv
module bankx_phase_mux
  import bankx_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic              col_sel,
  input  logic              force_low,
  output logic              phase_bit,
  output logic              ma8
);

  phase_e ph;

  always_comb begin
    ph        = col_sel ? PH_COL : PH_ROW;
    phase_bit = phase_pick(bank, ph);
    ma8       = force_low ? 1'b0 : phase_bit;
  end

endmodule

// File: rtl/dram_bank_ma8.sv
module dram_bank_ma8
  import bankx_pkg::*;
#(
  parameter logic [CPU_AW-1:0] LO_BASE      = 16'h0000,
  parameter int                LO_SPAN_LOG2 = 11,
  parameter logic [CPU_AW-1:0] HI_BASE      = 16'hC800,
  parameter int                HI_SPAN_LOG2 = 11
) (
  input  logic [15:0] cpu_addr,
  input  logic [1:0]  bank,
  input  logic        lo_common_en,
  input  logic        hi_common_en,
  input  logic        col_sel,
  output logic        ma8
);

  localparam int NUM_WIN = 2;

  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] win_hit;
  logic               common_hit;
  logic               phase_bit;

  assign win_en = {hi_common_en, lo_common_en};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [CPU_AW-1:0] WBASE = (w == 0) ? LO_BASE : HI_BASE;
    localparam int                WSPAN = (w == 0) ? LO_SPAN_LOG2 : HI_SPAN_LOG2;
    bankx_window #(
      .BASE      (WBASE),
      .SPAN_LOG2 (WSPAN)
    ) u_win (
      .addr (cpu_addr),
      .en   (win_en[w]),
      .hit  (win_hit[w])
    );
  end

  assign common_hit = |win_hit;

  bankx_phase_mux u_mux (
    .bank      (bank),
    .col_sel   (col_sel),
    .force_low (common_hit),
    .phase_bit (phase_bit),
    .ma8       (ma8)
  );

endmodule

// File: rtl/bankx_checker.sv
module bankx_checker (
  input logic [15:0] cpu_addr,
  input logic [1:0]  bank,
  input logic        lo_common_en,
  input logic        hi_common_en,
  input logic        col_sel,
  input logic [1:0]  win_hit,
  input logic        common_hit,
  input logic        phase_bit,
  input logic        ma8
);

  logic in_lo, in_hi;
  assign in_lo = (cpu_addr < 16'h0800);
  assign in_hi = (cpu_addr >= 16'hC800) && (cpu_addr <= 16'hCFFF);

  always_comb begin
    if (!common_hit && !col_sel)
      AST_ROW_A16: assert (ma8 == bank[0]);                       // R1
    if (!common_hit && col_sel)
      AST_COL_A17: assert (ma8 == bank[1]);                       // R2
    if (lo_common_en && in_lo)
      AST_LO_FORCE: assert (!ma8);                                // R3
    if (hi_common_en && in_hi)
      AST_HI_FORCE: assert (!ma8);                                // R4
    if (!(lo_common_en && in_lo) && !(hi_common_en && in_hi))
      AST_NO_FALSE_HIT: assert (!common_hit && ma8 == phase_bit); // R5
    if (!in_lo && !in_hi)
      AST_OUTSIDE_CLEAR: assert (win_hit == 2'b00);               // R6
    if (in_hi)
      AST_LO_EN_LOCAL: assert (!win_hit[0]);                      // R7
    if (bank == 2'b00)
      AST_BANK0_LOW: assert (!ma8);                               // R8
  end

endmodule

bind dram_bank_ma8 bankx_checker u_chk (
  .cpu_addr     (cpu_addr),
  .bank         (bank),
  .lo_common_en (lo_common_en),
  .hi_common_en (hi_common_en),
  .col_sel      (col_sel),
  .win_hit      (win_hit),
  .common_hit   (common_hit),
  .phase_bit    (phase_bit),
  .ma8          (ma8)
);

// File: tb/sim_dram_bank_ma8.sv
`timescale 1ns/1ps
module sim_dram_bank_ma8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [1:0]  bank = '0;
  logic        lo_en = 1'b0;
  logic        hi_en = 1'b0;
  logic        col_sel = 1'b0;
  logic        ma8;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  dram_bank_ma8 u0 (
    .cpu_addr     (cpu_addr),
    .bank         (bank),
    .lo_common_en (lo_en),
    .hi_common_en (hi_en),
    .col_sel      (col_sel),
    .ma8          (ma8)
  );

  // Behavioural reference: integer range tests.
  function automatic bit model(int a, int b, bit lo, bit hi, bit col);
    bit pinned;
    pinned = (lo && a >= 0 && a <= 2047) || (hi && a >= 51200 && a <= 53247);
    if (pinned) return 1'b0;
    if (col) return bit'((b / 2) % 2);
    return bit'(b % 2);
  endfunction

  function automatic string classify(int a, int b, bit lo, bit hi, bit col);
    bit wl, wh;
    wl = (a <= 2047);
    wh = (a >= 51200 && a <= 53247);
    if (lo && wl) return "R3";
    if (hi && wh) return "R4";
    if (wl || wh) return "R5";
    if (b == 0)   return "R8";
    return col ? "R2" : "R1";
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h bank=%0d lo=%0b hi=%0b col=%0b actual=%0b expected=%0b",
               tag, cpu_addr, bank, lo_en, hi_en, col_sel, got, exp);
    end
  endtask

  // Drive after a rising edge, compare at the following falling edge.
  task automatic apply(int a, int b, bit lo, bit hi, bit col, string tag);
    string t;
    @(posedge clk);
    cpu_addr = 16'(a);
    bank     = 2'(b);
    lo_en    = lo;
    hi_en    = hi;
    col_sel  = col;
    @(negedge clk);
    t = (tag == "") ? classify(a, b, lo, hi, col) : tag;
    check(t, ma8, model(a, b, lo, hi, col));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  int edges [8] = '{16'h0000, 16'h07FF, 16'h0800, 16'hC7FF,
                    16'hC800, 16'hCFFF, 16'hD000, 16'hFFFF};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", ma8, 1'b0);   // idle inputs during bench reset
    rst_n = 1'b1;

    // R1 / R2: phase mapping, all banks, outside windows
    for (int b = 0; b < 4; b++) begin
      apply(16'h4000, b, 1, 1, 0, "R1");
      apply(16'h4000, b, 1, 1, 1, "R2");
    end

    // R3 / R4 / R5 / R7: window edges, all enable combos, banks, phases
    for (int e = 0; e < 8; e++)
      for (int en = 0; en < 4; en++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 2; c++)
            apply(edges[e], b, bit'(en % 2), bit'(en / 2), bit'(c), "");

    // R6: just outside, both enables on, bank 3
    apply(16'h0800, 3, 1, 1, 0, "R6");
    apply(16'hC7FF, 3, 1, 1, 1, "R6");
    apply(16'hD000, 3, 1, 1, 0, "R6");
    apply(16'hD000, 3, 1, 1, 1, "R6");

    // R7: each enable alone, applied to the other window
    apply(16'hC900, 3, 1, 0, 0, "R7");
    apply(16'h0100, 3, 0, 1, 1, "R7");

    // R8: bank 0 everywhere
    apply(16'h2345, 0, 0, 0, 1, "R8");
    apply(16'hC800, 0, 0, 0, 0, "R8");

    // R9: toggle in/out of a window every cycle
    for (int i = 0; i < 8; i++)
      apply((i % 2 == 0) ? 16'h07FF : 16'h0800, 3, 1, 0, bit'(i / 4), "R9");
    for (int i = 0; i < 6; i++)
      apply(16'h4000, 1 + (i % 3), 0, 0, bit'(i % 2), "R9");

    // Random sweep biased toward the edges
    for (int i = 0; i < 3000; i++) begin
      int a;
      int r;
      r = int'($urandom_range(0, 3));
      if (r == 0) a = edges[$urandom_range(0, 7)];
      else if (r == 1) a = edges[$urandom_range(0, 7)] + int'($urandom_range(0, 2)) - 1;
      else a = int'($urandom_range(0, 65535));
      a = a & 16'hFFFF;
      apply(a, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "");
    end

    done = 1'b1;
    finish_run();
  end

endmodule